// File: doc/BRIEF.md
# Memory-Mapped Character Input Port

This block lets a 16-bit processor receive characters from an input device through two bus-visible registers. A status word at address 0xFE00 reports whether a character is waiting (bit 15) and carries a software-owned interrupt enable (bit 14). A data word at address 0xFE02 returns the waiting character in its low byte. The processor either polls the status word or waits for the interrupt request. It then reads the data word, and that read is the acknowledge that frees the port for the next character.

On the device side, characters arrive as a valid/ready stream with no back-pressure. `char_ready` tells the source whether a beat presented now would be taken. The source never holds `char_valid`. A beat offered while `char_ready` is low is discarded and cannot be recovered. On the processor side, the port sits in the load path of the memory data register. When the address selects one of the two registers, the register contents replace the memory read data. Any other address passes memory data through unchanged.

Top module: `kbd_input_port`

## Requirements
- R1: After reset the pending flag is 0, the interrupt enable is 0, the held character is 0x00, `irq` is 0 and `char_ready` is 1.
- R2: With `bus_addr` = 0xFE00, `mdr_data` shows the pending flag in bit 15 and the interrupt enable in bit 14, with bits [13:0] equal to zero, in the same cycle.
- R3: With `bus_addr` = 0xFE02, `mdr_data` shows the held character in bits [7:0], with bits [15:8] equal to zero, in the same cycle.
- R4: For any other address, `mdr_data` equals `mem_rdata`.
- R5: A beat with `char_valid` = 1 and `char_ready` = 1 stores `char_in` and sets the pending flag at the next clock edge.
- R6: While the pending flag is 1, newly offered characters are discarded, and the held character does not change.
- R7: A cycle with `bus_rd` = 1 and `bus_addr` = 0xFE02 clears the pending flag at the next edge, and the port accepts characters again.
- R8: A character offered in the same cycle as a data-register read is discarded, so the pending flag is 0 after that edge.
- R9: A write (`bus_wr` = 1) to 0xFE00 loads only the interrupt enable, from `bus_wdata[14]`. The pending flag cannot be changed by software.
- R10: `irq` is 1 exactly when both the pending flag and the interrupt enable are 1.
- R11: A write to 0xFE02 has no effect on the held character or on the pending flag.
- R12: `char_ready` is 1 only when the pending flag is 0 and no data-register read is in progress in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_rd | input | 1 | Processor read strobe |
| bus_wr | input | 1 | Processor write strobe |
| bus_wdata | input | 16 | Processor write data |
| mem_rdata | input | 16 | Read data from memory |
| mdr_data | output | 16 | Value to load into the memory data register |
| char_valid | input | 1 | Device character beat valid (single cycle) |
| char_in | input | 8 | Device character |
| char_ready | output | 1 | Port would accept a beat this cycle |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The read path is combinational, so `mdr_data` and `char_ready` are checked in the same cycle the address and strobes are applied. The bench samples them one nanosecond after driving on the falling edge. The pending flag, the held character and the interrupt enable are registered, so the effects of a beat, a data read or a status write are due one edge later. The bench confirms them by reading the status or data word after the next rising edge. `irq` follows those registers and is sampled in the cycle after the edge that changes them.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned BUS_W     = 16;
  localparam int unsigned CHAR_W    = 8;
  localparam int unsigned PEND_POS  = 15;
  localparam int unsigned IEN_POS   = 14;
  localparam logic [BUS_W-1:0] STAT_ADDR = 16'hFE00;
  localparam logic [BUS_W-1:0] CHAR_ADDR = 16'hFE02;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CHAR = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
  import kbd_port_pkg::*;
#(
  parameter int unsigned AW = BUS_W,
  parameter logic [AW-1:0] STAT_A = STAT_ADDR,
  parameter logic [AW-1:0] CHAR_A = CHAR_ADDR
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output rd_sel_e       sel,
  output logic          stat_wr,
  output logic          char_rd
);
  logic hit_stat;
  logic hit_char;

  assign hit_stat = (addr == STAT_A);
  assign hit_char = (addr == CHAR_A);

  always_comb begin
    if (hit_stat)      sel = SEL_STAT;
    else if (hit_char) sel = SEL_CHAR;
    else               sel = SEL_MEM;
  end

  assign stat_wr = wr & hit_stat;
  assign char_rd = rd & hit_char;
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture
  import kbd_port_pkg::*;
#(
  parameter int unsigned CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_valid,
  input  logic [CW-1:0] char_in,
  input  logic          char_rd,
  input  logic          stat_wr,
  input  logic          wr_ien,
  output logic          char_ready,
  output logic          pend_q,
  output logic          ien_q,
  output logic [CW-1:0] char_q
);
  logic take;

  assign char_ready = ~pend_q & ~char_rd;
  assign take       = char_valid & char_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      char_q <= '0;
    end else begin
      if (take) begin
        pend_q <= 1'b1;
        char_q <= char_in;
      end else if (char_rd) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (stat_wr) ien_q <= wr_ien;
  end

  AST_PEND_RISE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(char_valid)) else $error("pend rose without beat"); // R5
  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !char_rd) |=> ($stable(char_q) && pend_q)) else $error("held char changed"); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    char_rd |=> !pend_q) else $error("read did not clear"); // R7
  AST_IEN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ien_q) |-> $past(stat_wr)) else $error("ien changed without write"); // R9
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
  import kbd_port_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned CW = CHAR_W,
  parameter int unsigned PP = PEND_POS,
  parameter int unsigned IP = IEN_POS
) (
  input  rd_sel_e       sel,
  input  logic          pend,
  input  logic          ien,
  input  logic [CW-1:0] chr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mdr_data
);
  logic [DW-1:0] stat_word;
  logic [DW-1:0] char_word;

  for (genvar b = 0; b < DW; b++) begin : g_bits
    if (b == PP) begin : g_pend
      assign stat_word[b] = pend;
    end else if (b == IP) begin : g_ien
      assign stat_word[b] = ien;
    end else begin : g_zero
      assign stat_word[b] = 1'b0;
    end
    if (b < CW) begin : g_chr
      assign char_word[b] = chr[b];
    end else begin : g_pad
      assign char_word[b] = 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: mdr_data = stat_word;
      SEL_CHAR: mdr_data = char_word;
      default:  mdr_data = mem_rdata;
    endcase
  end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_port_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned CW = CHAR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mdr_data,
  input  logic          char_valid,
  input  logic [CW-1:0] char_in,
  output logic          char_ready,
  output logic          irq
);
  rd_sel_e       sel;
  logic          stat_wr;
  logic          char_rd;
  logic          pend_q;
  logic          ien_q;
  logic [CW-1:0] char_q;

  kbd_addr_decode #(.AW(DW)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .sel(sel), .stat_wr(stat_wr), .char_rd(char_rd)
  );

  kbd_capture #(.CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .char_valid(char_valid), .char_in(char_in),
    .char_rd(char_rd), .stat_wr(stat_wr), .wr_ien(bus_wdata[IEN_POS]),
    .char_ready(char_ready), .pend_q(pend_q), .ien_q(ien_q), .char_q(char_q)
  );

  kbd_read_mux #(.DW(DW), .CW(CW)) u_mux (
    .sel(sel), .pend(pend_q), .ien(ien_q), .chr(char_q),
    .mem_rdata(mem_rdata), .mdr_data(mdr_data)
  );

  assign irq = pend_q & ien_q;

  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_ADDR) |-> (mdr_data[IEN_POS-1:0] == '0)) else $error("status low bits"); // R2
  AST_CHAR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CHAR_ADDR) |-> (mdr_data[DW-1:CW] == '0)) else $error("data high bits"); // R3
  AST_IRQ_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !char_ready) else $error("irq with port open"); // R10
  AST_SAME_CYCLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rd && char_valid) |=> !pend_q) else $error("beat during read kept"); // R8
endmodule

// File: tb/kbd_input_port_tb.sv
module kbd_input_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] mem_rdata = 16'h0000;
  logic [15:0] mdr_data;
  logic        char_valid = 1'b0;
  logic [7:0]  char_in = 8'h00;
  logic        char_ready;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_CHAR = 16'hFE02;

  always #5 clk = ~clk;

  kbd_input_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
    .mdr_data(mdr_data), .char_valid(char_valid), .char_in(char_in),
    .char_ready(char_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_rd = 0; bus_wr = 0; char_valid = 0; bus_addr = 16'h0000;
  endtask

  // one bus cycle starting at negedge; returns combinational read value
  task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                     input logic [15:0] wd, input logic v, input logic [7:0] c,
                     output logic [15:0] rv, output logic cr);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; char_valid = v; char_in = c;
    #1; rv = mdr_data; cr = char_ready;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic peek(input logic [15:0] a, output logic [15:0] rv);
    @(negedge clk); bus_addr = a; bus_rd = 0; #1; rv = mdr_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 char_ready", {15'd0, char_ready}, 16'h1);
    peek(A_STAT, v); chk("R1 status", v, 16'h0000);
    peek(A_CHAR, v); chk("R1 data", v, 16'h0000);
  endtask

  task automatic t_capture();
    logic [15:0] v; logic cr;
    cyc(16'h0, 0, 0, 0, 1, 8'h41, v, cr);
    chk("R5 accepted", {15'd0, cr}, 16'h1);
    peek(A_STAT, v); chk("R5 R2 status pending", v, 16'h8000);
    peek(A_CHAR, v); chk("R5 R3 data", v, 16'h0041);
    chk("R12 closed while pending", {15'd0, char_ready}, 16'h0);
  endtask

  task automatic t_drop_pending();
    logic [15:0] v; logic cr;
    cyc(16'h0, 0, 0, 0, 1, 8'h42, v, cr);
    peek(A_CHAR, v); chk("R6 data kept", v, 16'h0041);
  endtask

  task automatic t_read_clears();
    logic [15:0] v; logic cr;
    cyc(A_CHAR, 1, 0, 0, 0, 0, v, cr);
    chk("R3 read value", v, 16'h0041);
    peek(A_STAT, v); chk("R7 cleared", v, 16'h0000);
    chk("R7 reopened", {15'd0, char_ready}, 16'h1);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v; logic cr;
    cyc(A_CHAR, 1, 0, 0, 1, 8'h43, v, cr);
    chk("R12 closed during read", {15'd0, cr}, 16'h0);
    peek(A_STAT, v); chk("R8 not pending", v, 16'h0000);
    peek(A_CHAR, v); chk("R8 data kept", v, 16'h0041);
  endtask

  task automatic t_status_write_irq();
    logic [15:0] v; logic cr;
    cyc(A_STAT, 0, 1, 16'hFFFF, 0, 0, v, cr);
    peek(A_STAT, v); chk("R9 only enable set", v, 16'h4000);
    chk("R10 no irq without pending", {15'd0, irq}, 16'h0);
    cyc(16'h0, 0, 0, 0, 1, 8'h5A, v, cr);
    chk("R10 irq raised", {15'd0, irq}, 16'h1);
    peek(A_STAT, v); chk("R2 both bits", v, 16'hC000);
    cyc(A_STAT, 0, 1, 16'h0000, 0, 0, v, cr);
    peek(A_STAT, v); chk("R9 pending not writable", v, 16'h8000);
    chk("R10 irq dropped", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_data_write();
    logic [15:0] v; logic cr;
    cyc(A_CHAR, 0, 1, 16'h1234, 0, 0, v, cr);
    peek(A_CHAR, v); chk("R11 data unchanged", v, 16'h005A);
    peek(A_STAT, v); chk("R11 pending unchanged", v, 16'h8000);
  endtask

  task automatic t_passthrough();
    logic [15:0] v;
    mem_rdata = 16'hBEEF;
    peek(16'h3000, v); chk("R4 plain address", v, 16'hBEEF);
    peek(16'hFE04, v); chk("R4 neighbour address", v, 16'hBEEF);
    peek(16'hFE01, v); chk("R4 odd address", v, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    t_reset();
    t_capture();
    t_drop_pending();
    t_read_clears();
    t_same_cycle();
    t_status_write_irq();
    t_data_write();
    t_passthrough();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done == 1'b1);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule